// File: doc/BRIEF.md
# Eight-Bit Arithmetic, Logic and Comparison Unit

This block is a purely combinational eight-bit arithmetic and logic unit. It takes two eight-bit operands and a four-bit function code, and it produces one eight-bit result in the same cycle. The fourteen functions are:

- wrapping addition and subtraction;
- three bitwise operations;
- six unsigned relational tests;
- a logical right shift, a left shift and an arithmetic right shift.

A relational test returns a boolean word with the answer in bit 0 and zeros above it. Branch logic can therefore test the result directly, without a separate flag path. The two function codes left over are reserved and always give zero.

The unit sits between operand latches and a writeback or branch-decision stage. It holds no state, so its result follows its inputs within the same cycle.

Top module: `alu8`

## Requirements
- R1: Function code 0 gives op_a + op_b modulo 256.
- R2: Function code 1 gives op_a - op_b modulo 256.
- R3: Function codes 2, 3 and 4 give the bitwise AND, OR and XOR of the operands.
- R4: Function codes 5 (greater than) and 6 (less than) compare the operands as unsigned values. The result is 1 when the relation holds and 0 otherwise. Only bit 0 may be set.
- R5: Function codes 7 (greater or equal) and 8 (less or equal) compare the operands as unsigned values and return 1 or 0 in bit 0, with bits 7 to 1 zero.
- R6: Function codes 9 (equal) and 10 (not equal) return 1 or 0 in bit 0, with bits 7 to 1 zero.
- R7: Function code 11 shifts op_a right, filling with zeros, by op_b[2:0] places when op_b < 8. It gives 0 when op_b >= 8.
- R8: Function code 12 shifts op_a left, filling with zeros, by op_b[2:0] places when op_b < 8. It gives 0 when op_b >= 8.
- R9: Function code 13 shifts op_a right by op_b[2:0] places, filling with copies of op_a[7], when op_b < 8. When op_b >= 8 every bit of the result equals op_a[7].
- R10: Function codes 14 and 15 give a result of 0 for any operands.
- R11: The result depends only on the present inputs. With all inputs at zero the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand; the value that is shifted |
| op_b | input | 8 | Second operand; also the shift distance |
| func | input | 4 | Function code |
| result | output | 8 | Result of the selected function |

## Verification
For one pair of operands, several relational answers must hold at once. When the operands are equal, greater-or-equal, less-or-equal and equal must all return 1, while greater, less and not-equal must all return 0. The bench covers this by sweeping every first operand both against a fixed set of second operands and against itself. It then judges each code against an answer computed with integer arithmetic.

The shift distance crosses the boundary at 8, where the zero-fill and sign-fill rules take over. It is probed at 7, 8, 9, 15, 16, 128 and 255, for operands with the top bit both clear and set.

// File: rtl/alu8.sv
module alu8 #(
  parameter int W = 8
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   func,
  output logic [W-1:0] result
);
  localparam int SHW = $clog2(W);

  localparam logic [3:0] F_ADD = 4'd0,  F_SUB = 4'd1,  F_AND = 4'd2,  F_OR  = 4'd3;
  localparam logic [3:0] F_XOR = 4'd4,  F_GT  = 4'd5,  F_LT  = 4'd6,  F_GE  = 4'd7;
  localparam logic [3:0] F_LE  = 4'd8,  F_EQ  = 4'd9,  F_NE  = 4'd10, F_SRL = 4'd11;
  localparam logic [3:0] F_SLL = 4'd12, F_SRA = 4'd13;

  logic [W:0]     diff;
  logic           borrow, zero;
  logic [SHW-1:0] amt;
  logic           far;
  logic [W-1:0]   srl_v, sll_v, sra_v;

  assign diff   = {1'b0, op_a} - {1'b0, op_b};
  assign borrow = diff[W];
  assign zero   = (diff[W-1:0] == '0);

  assign amt   = op_b[SHW-1:0];
  assign far   = |op_b[W-1:SHW];
  assign srl_v = far ? '0 : (op_a >> amt);
  assign sll_v = far ? '0 : (op_a << amt);
  assign sra_v = far ? {W{op_a[W-1]}} : W'($signed(op_a) >>> amt);

  always_comb begin
    result = '0;
    case (func)
      F_ADD: result = op_a + op_b;
      F_SUB: result = diff[W-1:0];
      F_AND: result = op_a & op_b;
      F_OR:  result = op_a | op_b;
      F_XOR: result = op_a ^ op_b;
      F_GT:  result[0] = !borrow && !zero;
      F_LT:  result[0] = borrow;
      F_GE:  result[0] = !borrow;
      F_LE:  result[0] = borrow || zero;
      F_EQ:  result[0] = zero;
      F_NE:  result[0] = !zero;
      F_SRL: result = srl_v;
      F_SLL: result = sll_v;
      F_SRA: result = sra_v;
      default: result = '0;
    endcase
  end

  always_comb begin
    // R1
    if (func == F_ADD) add_inverse_chk: assert (W'(result - op_b) == op_a);
    // R2
    if (func == F_SUB) sub_inverse_chk: assert (W'(result + op_b) == op_a);
    // R4
    if (func >= F_GT && func <= F_NE) bool_width_chk: assert (result[W-1:1] == '0);
    // R7
    if (func == F_SRL && op_b != '0) srl_top_chk: assert (result[W-1] == 1'b0);
    // R8
    if (func == F_SLL && op_b != '0) sll_bottom_chk: assert (result[0] == 1'b0);
    // R9
    if (func == F_SRA) sra_sign_chk: assert (result[W-1] == op_a[W-1]);
    // R10
    if (func > F_SRA) reserved_zero_chk: assert (result == '0);
  end
endmodule

// File: tb/alu8_test.sv
module alu8_test;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic [3:0] f;
  logic [7:0] y;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8 uut (.op_a(a), .op_b(b), .func(f), .result(y));

  function automatic int expect_of(int fc, int av, int bv);
    int r;
    case (fc)
      0: r = (av + bv) & 255;
      1: r = (av - bv + 256) & 255;
      2: r = av & bv;
      3: r = av | bv;
      4: r = av ^ bv;
      5: r = (av > bv) ? 1 : 0;
      6: r = (av < bv) ? 1 : 0;
      7: r = (av >= bv) ? 1 : 0;
      8: r = (av <= bv) ? 1 : 0;
      9: r = (av == bv) ? 1 : 0;
      10: r = (av != bv) ? 1 : 0;
      11: r = (bv >= 8) ? 0 : (av >> bv);
      12: r = (bv >= 8) ? 0 : ((av << bv) & 255);
      13: begin
        if (bv >= 8) r = (av >= 128) ? 255 : 0;
        else begin
          r = av >> bv;
          if (av >= 128) r = r | ((255 << (8 - bv)) & 255);
        end
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(int fc);
    case (fc)
      0: return "R1";
      1: return "R2";
      2, 3, 4: return "R3";
      5, 6: return "R4";
      7, 8: return "R5";
      9, 10: return "R6";
      11: return "R7";
      12: return "R8";
      13: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(int fc, int av, int bv);
    int e;
    f = 4'(fc); a = 8'(av); b = 8'(bv);
    #1;
    e = expect_of(fc, av, bv);
    total++;
    if (int'(y) != e) begin
      bad++;
      if (bad < 20)
        $display("FAIL %s func=%0d a=%0d b=%0d actual=%0d expected=%0d",
                 tag_of(fc), fc, av, bv, y, e);
    end
  endtask

  initial begin
    int blist[17] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 15, 16, 100, 127, 128, 200, 255};
    a = '0; b = '0; f = '0;
    #1;
    // R11: all-zero inputs give zero
    total++;
    if (y !== 8'd0) begin
      bad++;
      $display("FAIL R11 zero inputs actual=%0d expected=0", y);
    end
    for (int fc = 0; fc < 16; fc++)
      for (int av = 0; av < 256; av++) begin
        for (int k = 0; k < 17; k++) apply(fc, av, blist[k]);
        apply(fc, av, av);
        apply(fc, av, 255 - av);
      end
    // R11: same operands, result changes immediately with func alone
    apply(9, 77, 77);
    apply(10, 77, 77);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule